// File: doc/BRIEF.md
# SPI Byte-Strobed FIFO Data Port

This block is the payload path of a radio front end in buffered or packet operation. A host on an SPI bus moves bytes into a transmit queue or out of a receive queue. No address phase exists. Each period where the data select is low carries exactly one byte. When that select returns high, the queue pointer steps to the next entry. The port listens only while the data select is low and the separate configuration select is high. With any other pair of levels, the port ignores the bus.

One internal queue serves both directions, and a direction input sets the roles. With `dir_rx` low (transmit), the host fills the queue and the radio core drains it through `core_pop`. With `dir_rx` high (receive), the core fills it through `core_push` and the host drains it. Two interrupt lines pace the host. `irq0` asks for service: data waiting in receive, or room below a programmable level in transmit. `irq1` flags a full queue. A sticky flag records any push that was refused because the queue was full.

The SPI pins are brought into the `clk` domain through a synchronizer chain of parameterized length. SPI timing is mode 0: MOSI is sampled on the SCK rise, MISO changes on the SCK fall, and bytes go MSB first.

Top module: `spi_strobe_fifo`

## Requirements
- R1: After reset the queue is empty, `core_rdata_vld`, `irq1`, `ovf_flag` and `spi_miso` are 0, and `irq0` equals 1 in transmit mode when `tx_level_thr` is above 0.
- R2: The port is active only while `spi_dsel_n` is 0 and `spi_csel_n` is 1. With any other combination, SCK and MOSI cause no push or pop, and `spi_miso` stays 0.
- R3: In transmit mode (`dir_rx`=0), the 8 MOSI bits sampled on the SCK rises of one window are assembled MSB first. They are pushed when `spi_dsel_n` returns high, and the core reads them back at `core_rdata` in the order they were written.
- R4: A window with fewer than 8 SCK rising edges neither pushes nor pops.
- R5: A push to a full queue is dropped, the queued contents are unchanged, and `ovf_flag` goes to 1 and stays 1 until reset.
- R6: In receive mode (`dir_rx`=1), the head entry is loaded when the window opens. It is shifted out MSB first on `spi_miso`, with a new bit after each SCK fall, and it is popped when `spi_dsel_n` returns high.
- R7: A host read of an empty queue returns 0x00 and pops nothing, even if the core pushes during that window.
- R8: `irq0` is 1 in receive mode when the queue is non-empty. In transmit mode it is 1 when the fill level is below `tx_level_thr`.
- R9: `irq1` is 1 exactly when the queue holds DEPTH entries.
- R10: A push and a pop in the same clock cycle both take effect, and FIFO order is kept.
- R11: A window that ends because `spi_csel_n` falls, rather than because `spi_dsel_n` rises, commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1 = receive (core fills, host drains), 0 = transmit |
| tx_level_thr | input | 7 | Transmit level below which irq0 is raised |
| spi_sck | input | 1 | SPI clock |
| spi_dsel_n | input | 1 | Data select, active low, toggled once per byte |
| spi_csel_n | input | 1 | Configuration select; must be high for this port to respond |
| spi_mosi | input | 1 | Host-to-port serial data |
| spi_miso | output | 1 | Port-to-host serial data |
| core_push | input | 1 | Core write strobe (receive mode) |
| core_wdata | input | 8 | Core write byte |
| core_pop | input | 1 | Core read strobe (transmit mode) |
| core_rdata | output | 8 | Head entry of the queue |
| core_rdata_vld | output | 1 | Queue not empty |
| irq0 | output | 1 | Service request |
| irq1 | output | 1 | Queue full |
| ovf_flag | output | 1 | Sticky dropped-push flag |

## Verification
Two things can land in the same clock: a host byte committed at the end of a window, and a core pop from the other side. The bench preloads 60 bytes and opens a host write window. It then drains continuously with `core_pop` across the whole span in which the commit must occur, so the commit cycle falls among the pops while the queue is non-empty. It judges the result by the complete drained sequence: the 60 preloaded bytes in order, then the new byte, 61 entries with none lost or doubled. The full-queue case is provoked the same way. The bench pushes into a full queue and checks that the drained contents end at the last accepted byte.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } sfp_dir_e;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sfp_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("sfp_sync: W must be at least 1");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= RST_VAL;
         end else if (s == 0) begin
            stage_q[s] <= d;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sfp_store.sv
module sfp_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          drop
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sfp_store: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign drop    = push && full;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(level)); // R5
   AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty) |=> $stable(level)); // R10
endmodule

// File: rtl/sfp_frame.sv
module sfp_frame
   import sfp_pkg::*;
#(
   parameter int          DW   = 8,
   parameter logic [DW-1:0] FILL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sck,
   input  logic          dsel_n,
   input  logic          csel_n,
   input  logic          mosi,
   input  sfp_dir_e      dir,
   input  logic [DW-1:0] head,
   input  logic          head_vld,
   output logic          miso,
   output logic          host_push,
   output logic          host_pop,
   output logic [DW-1:0] byte_in
);
   localparam int BCW = $clog2(DW + 1);

   if (DW < 2) begin : g_bad_dw
      $error("sfp_frame: DW must be at least 2");
   end

   logic           act, act_q, sck_q;
   logic           opening, closing_ok, byte_done;
   logic           sck_rise, sck_fall;
   logic [BCW-1:0] nbits;
   logic [DW-1:0]  shreg;
   logic           loaded_real;

   assign act        = !dsel_n && csel_n;
   assign opening    = act && !act_q;
   assign closing_ok = !act && act_q && dsel_n && csel_n;
   assign sck_rise   = act && act_q && sck && !sck_q;
   assign sck_fall   = act && act_q && !sck && sck_q;
   assign byte_done  = (nbits == BCW'(DW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         sck_q       <= 1'b0;
         nbits       <= '0;
         shreg       <= '0;
         loaded_real <= 1'b0;
         host_push   <= 1'b0;
         host_pop    <= 1'b0;
      end else begin
         act_q     <= act;
         sck_q     <= sck;
         host_push <= 1'b0;
         host_pop  <= 1'b0;
         if (opening) begin
            nbits <= '0;
            if (dir == DIR_RX) begin
               shreg       <= head_vld ? head : FILL;
               loaded_real <= head_vld;
            end
         end else if (act) begin
            if (sck_rise) begin
               if (!byte_done) nbits <= nbits + 1'b1;
               if (dir == DIR_TX) shreg <= {shreg[DW-2:0], mosi};
            end
            if (sck_fall && dir == DIR_RX) shreg <= {shreg[DW-2:0], 1'b0};
         end
         if (closing_ok && byte_done) begin
            host_push <= (dir == DIR_TX);
            host_pop  <= (dir == DIR_RX) && loaded_real;
         end
      end
   end

   assign byte_in = shreg;
   assign miso    = (act_q && dir == DIR_RX) ? shreg[DW-1] : 1'b0;

   AST_PUSH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      host_push |=> !host_push); // R3
   AST_POP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      host_pop |=> !host_pop); // R6
endmodule

// File: rtl/spi_strobe_fifo.sv
module spi_strobe_fifo
   import sfp_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          DEPTH       = 64,
   parameter int          SYNC_STAGES = 2,
   parameter logic [DW-1:0] EMPTY_FILL = '0,
   localparam int         CW          = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_rx,
   input  logic [CW-1:0] tx_level_thr,
   input  logic          spi_sck,
   input  logic          spi_dsel_n,
   input  logic          spi_csel_n,
   input  logic          spi_mosi,
   output logic          spi_miso,
   input  logic          core_push,
   input  logic [DW-1:0] core_wdata,
   input  logic          core_pop,
   output logic [DW-1:0] core_rdata,
   output logic          core_rdata_vld,
   output logic          irq0,
   output logic          irq1,
   output logic          ovf_flag
);
   sfp_dir_e      dir;
   logic [3:0]    pins_s;
   logic          host_push, host_pop;
   logic [DW-1:0] host_byte, head;
   logic [CW-1:0] level;
   logic          full, empty, drop;

   assign dir = dir_rx ? DIR_RX : DIR_TX;

   sfp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_sck, spi_dsel_n, spi_csel_n, spi_mosi}),
      .q(pins_s)
   );

   sfp_frame #(.DW(DW), .FILL(EMPTY_FILL)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sck(pins_s[3]), .dsel_n(pins_s[2]), .csel_n(pins_s[1]), .mosi(pins_s[0]),
      .dir(dir), .head(head), .head_vld(!empty),
      .miso(spi_miso), .host_push(host_push), .host_pop(host_pop),
      .byte_in(host_byte)
   );

   sfp_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(dir == DIR_RX ? core_push : host_push),
      .wdata(dir == DIR_RX ? core_wdata : host_byte),
      .pop(dir == DIR_RX ? host_pop : core_pop),
      .head(head), .level(level), .full(full), .empty(empty), .drop(drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovf_flag <= 1'b0;
      else if (drop) ovf_flag <= 1'b1;
   end

   assign core_rdata     = head;
   assign core_rdata_vld = !empty;
   assign irq1           = full;
   assign irq0           = (dir == DIR_RX) ? !empty : (level < tx_level_thr);

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag); // R5
   AST_FULL_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_RX && irq1) |-> irq0); // R8
endmodule

// File: tb/spi_strobe_fifo_bench.sv
module spi_strobe_fifo_bench;
   localparam int HALF = 6;
   localparam int CW   = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dir_rx = 1'b0;
   logic [CW-1:0] tx_level_thr = 7'd4;
   logic          spi_sck = 1'b0, spi_dsel_n = 1'b1, spi_csel_n = 1'b1, spi_mosi = 1'b0;
   logic          spi_miso;
   logic          core_push = 1'b0, core_pop = 1'b0;
   logic [7:0]    core_wdata = '0;
   logic [7:0]    core_rdata;
   logic          core_rdata_vld, irq0, irq1, ovf_flag;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   spi_strobe_fifo u_spi_strobe_fifo (
      .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .tx_level_thr(tx_level_thr),
      .spi_sck(spi_sck), .spi_dsel_n(spi_dsel_n), .spi_csel_n(spi_csel_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .core_push(core_push), .core_wdata(core_wdata), .core_pop(core_pop),
      .core_rdata(core_rdata), .core_rdata_vld(core_rdata_vld),
      .irq0(irq0), .irq1(irq1), .ovf_flag(ovf_flag)
   );

   localparam logic [7:0] VEC [8] = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h81, 8'h7E, 8'h12, 8'hC9};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic gap();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic spi_xfer(input logic [7:0] tx, input int nbits, input bit abort,
                           output logic [7:0] rx);
      rx = '0;
      @(negedge clk) spi_dsel_n = 1'b0;
      gap();
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = tx[7-i];
         gap();
         rx[7-i] = spi_miso;
         spi_sck = 1'b1;
         gap();
         spi_sck = 1'b0;
      end
      gap();
      if (abort) begin spi_csel_n = 1'b0; gap(); end
      spi_dsel_n = 1'b1;
      gap();
      spi_csel_n = 1'b1;
      gap(); gap();
   endtask

   task automatic host_wr(input logic [7:0] d);
      logic [7:0] dummy;
      spi_xfer(d, 8, 1'b0, dummy);
   endtask

   task automatic core_take(output logic [7:0] d);
      @(negedge clk);
      d = core_rdata;
      core_pop = 1'b1;
      @(negedge clk) core_pop = 1'b0;
   endtask

   task automatic core_put(input logic [7:0] d);
      @(negedge clk);
      core_wdata = d;
      core_push = 1'b1;
      @(negedge clk) core_push = 1'b0;
   endtask

   logic [7:0] got [128];
   int         ngot;

   initial begin : main
      logic [7:0] d, rx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk(core_rdata_vld == 1'b0, "R1 vld", core_rdata_vld, 0);
      chk(irq1 == 1'b0, "R1 irq1", irq1, 0);
      chk(ovf_flag == 1'b0, "R1 ovf", ovf_flag, 0);
      chk(spi_miso == 1'b0, "R1 miso", spi_miso, 0);
      chk(irq0 == 1'b1, "R1 irq0", irq0, 1);

      // R3 table walk: host writes, core drains in order
      foreach (VEC[i]) host_wr(VEC[i]);
      chk(irq0 == 1'b0, "R8 tx level 8 not below 4", irq0, 0);
      foreach (VEC[i]) begin
         core_take(d);
         chk(d == VEC[i], "R3 order", d, VEC[i]);
      end
      @(negedge clk);
      chk(core_rdata_vld == 1'b0, "R3 drained", core_rdata_vld, 0);

      // R4 short window
      spi_xfer(8'hAA, 5, 1'b0, rx);
      chk(core_rdata_vld == 1'b0, "R4 short write", core_rdata_vld, 0);

      // R2 config select low: port ignores bus
      @(negedge clk) spi_csel_n = 1'b0;
      spi_xfer(8'h55, 8, 1'b0, rx);
      chk(core_rdata_vld == 1'b0, "R2 cfg low", core_rdata_vld, 0);
      // R2 SCK toggles while data select high
      for (int i = 0; i < 8; i++) begin
         spi_mosi = 1'b1; gap(); spi_sck = 1'b1; gap(); spi_sck = 1'b0;
      end
      gap(); gap();
      chk(core_rdata_vld == 1'b0, "R2 dsel high", core_rdata_vld, 0);

      // R11 window ended by config select
      spi_xfer(8'h66, 8, 1'b1, rx);
      chk(core_rdata_vld == 1'b0, "R11 abort", core_rdata_vld, 0);

      // R5 R9 fill and overflow
      for (int i = 0; i < 64; i++) host_wr(8'(i));
      chk(irq1 == 1'b1, "R9 full", irq1, 1);
      chk(ovf_flag == 1'b0, "R5 no ovf yet", ovf_flag, 0);
      host_wr(8'hEE);
      chk(ovf_flag == 1'b1, "R5 ovf set", ovf_flag, 1);
      core_take(d);
      chk(d == 8'h00, "R5 head kept", d, 0);
      chk(irq1 == 1'b0, "R9 not full", irq1, 0);
      for (int i = 1; i < 64; i++) begin
         core_take(d);
         if (i == 63) chk(d == 8'd63, "R5 tail is last accepted", d, 63);
      end
      @(negedge clk);
      chk(core_rdata_vld == 1'b0, "R5 no dropped byte", core_rdata_vld, 0);
      chk(ovf_flag == 1'b1, "R5 sticky", ovf_flag, 1);

      // R10 commit and core pop in the same cycle
      for (int i = 0; i < 60; i++) host_wr(8'(8'h40 + i));
      ngot = 0;
      fork
         host_wr(8'hA5);
         begin
            repeat (80) @(negedge clk);
            for (int k = 0; k < 70; k++) begin
               @(negedge clk);
               if (core_rdata_vld) begin
                  got[ngot] = core_rdata; ngot++; core_pop = 1'b1;
               end else core_pop = 1'b0;
            end
            core_pop = 1'b0;
         end
      join
      while (core_rdata_vld) begin
         core_take(d); got[ngot] = d; ngot++;
      end
      chk(ngot == 61, "R10 count", ngot, 61);
      begin
         int bad = 0;
         for (int i = 0; i < 60; i++) if (got[i] != 8'(8'h40 + i)) bad++;
         chk(bad == 0, "R10 order", bad, 0);
      end
      chk(got[60] == 8'hA5, "R10 last", got[60], 8'hA5);

      // R8 transmit threshold boundary
      tx_level_thr = 7'd3;
      host_wr(8'h01); host_wr(8'h02);
      chk(irq0 == 1'b1, "R8 level 2 below 3", irq0, 1);
      host_wr(8'h03);
      chk(irq0 == 1'b0, "R8 level 3", irq0, 0);
      repeat (3) core_take(d);

      // receive mode
      @(negedge clk) dir_rx = 1'b1;
      @(negedge clk);
      chk(irq0 == 1'b0, "R8 rx empty", irq0, 0);
      // R7 empty read, core pushes mid-window
      fork
         spi_xfer(8'h00, 8, 1'b0, rx);
         begin repeat (40) @(negedge clk); core_put(8'h99); end
      join
      chk(rx == 8'h00, "R7 empty read", rx, 0);
      chk(core_rdata_vld == 1'b1, "R7 no pop", core_rdata_vld, 1);
      spi_xfer(8'h00, 8, 1'b0, rx);
      chk(rx == 8'h99, "R7 byte survives", rx, 8'h99);

      core_put(8'hC3); core_put(8'h5A); core_put(8'h81);
      chk(irq0 == 1'b1, "R8 rx nonempty", irq0, 1);
      // R4 short read pops nothing
      spi_xfer(8'h00, 4, 1'b0, rx);
      spi_xfer(8'h00, 8, 1'b0, rx);
      chk(rx == 8'hC3, "R6 R4 first", rx, 8'hC3);
      spi_xfer(8'h00, 8, 1'b0, rx);
      chk(rx == 8'h5A, "R6 second", rx, 8'h5A);
      spi_xfer(8'h00, 8, 1'b0, rx);
      chk(rx == 8'h81, "R6 third", rx, 8'h81);
      chk(irq0 == 1'b0, "R8 rx drained", irq0, 0);
      chk(spi_miso == 1'b0, "R2 miso idle", spi_miso, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule